// File: doc/BRIEF.md
# Serial PHY management master

This block drives the two-wire management bus that reaches the registers of an Ethernet PHY. Software programs a clock divider, a PHY address and, for writes, a 16-bit value. It then writes the control word with the go bit set. The block emits one complete management frame on its clock and data lines. On a read it captures the 16 bits the PHY returns into a receive register. The go bit is the busy indicator: it reads back as 1 for the whole frame and drops to 0 on the cycle the frame ends. On that same cycle a completion flag rises, and that flag drives the interrupt output.

The management clock runs only during a frame and idles low. Its period is 2·(DIV+1) system clocks. Software must pick DIV so that the clock stays at or below 2.5 MHz. The data pin is modelled as separate output, output-enable and input signals.

Register map (word offsets on `wr_addr`/`rd_addr`):
- Offset 0 is control: bit 0 is go/busy, bit 1 selects write (1) or read (0), and bits 7:3 hold the PHY register number.
- Offset 1 is the divider.
- Offset 2 is the PHY address, in bits 4:0.
- Offset 3 is the transmit value.
- Offset 4 is the receive value, which is read-only.
- Offset 5 is the completion flag in bit 0. Writing 1 to it clears the flag.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset every register reads 0, `mdc` is low, `mdio_oe` is low, `mdio_out` is high and `irq` is low.
- R2: While a frame runs, `mdc` toggles every DIV+1 system cycles and is low when idle. A frame lasts exactly 128·(DIV+1) cycles, counted from the clock edge that accepts the go write to the edge at which busy drops.
- R3: Control bit 0 reads 1 on every cycle of a frame and reads 0 once the frame has finished.
- R4: A write frame, sampled at each `mdc` rising edge, is sent MSB first. It consists of 32 ones, then 01, then opcode 01, then the 5-bit PHY address, then the 5-bit register number, then turnaround 10, then the 16 transmit bits. `mdio_oe` is high for all 64 bits.
- R5: A read frame carries the same first 46 bits, except that its opcode is 10. `mdio_oe` is high only for those 46 bits and low from the turnaround onward.
- R6: On a read, `mdio_in` is sampled at the `mdc` rising edges of bits 48 to 63, MSB first. The resulting value appears at offset 4 when the frame ends.
- R7: `mdio_out` never changes on the edge where `mdc` rises. It moves only where `mdc` falls.
- R8: The completion flag and `irq` rise on the cycle a frame ends. Writing 0 to offset 5 leaves the flag set, and writing 1 clears it.
- R9: A write to the PHY address register during a frame is ignored.
- R10: A control write during a frame is ignored. It neither restarts the frame nor changes its register number.
- R11: A divider write during a frame is ignored, so the frame's length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 32 | Register write value |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 32 | Register read value (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Output enable for the data pin |
| mdio_in | input | 1 | Management data from the pin |
| irq | output | 1 | Completion flag |

## Verification
The hardest case to reach from the ports is a register write that arrives in the middle of a running frame. The guards for this case only matter while busy is high, and a normal software flow never produces such a write. The bench therefore counts cycles after the go edge and injects PHY-address, control and divider writes partway through one frame. It then checks the frame length, the captured address bits, the register readback, and that no second frame follows. A bench-side PHY model drives the read-data bits on `mdc` falling edges and records every bit at each rising edge. This lets both frame directions be compared bit for bit across random dividers and data.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int unsigned PHY_AW      = 5;
    localparam int unsigned REG_AW      = 5;
    localparam int unsigned MD_W        = 16;
    localparam int unsigned FRAME_BITS  = 64;
    localparam int unsigned PRE_BITS    = 32;
    localparam int unsigned TA_FIRST    = 46;
    localparam int unsigned DATA_FIRST  = 48;
    localparam int unsigned IDX_W       = $clog2(FRAME_BITS);

    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_DIV  = 3'd1;
    localparam logic [2:0] OFS_PHY  = 3'd2;
    localparam logic [2:0] OFS_TXD  = 3'd3;
    localparam logic [2:0] OFS_RXD  = 3'd4;
    localparam logic [2:0] OFS_IRQ  = 3'd5;

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
endpackage

// File: rtl/mdm_clkdiv.sv
module mdm_clkdiv #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_t;

    div_t st_d, st_q;
    logic wrap;

    assign wrap      = run && (st_q.cnt == div);
    assign rise_tick = wrap && !st_q.mdc;
    assign fall_tick = wrap && st_q.mdc;
    assign mdc       = st_q.mdc;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = !st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mdm_frame_engine.sv
module mdm_frame_engine
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              launch_wr,
    input  logic [PHY_AW-1:0] launch_phy,
    input  logic [REG_AW-1:0] launch_reg,
    input  logic [MD_W-1:0]   launch_txd,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_in,
    output logic              active,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              done,
    output logic [MD_W-1:0]   rx_word
);
    localparam int unsigned HDR_W = FRAME_BITS - PRE_BITS;

    typedef struct packed {
        logic             active;
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [HDR_W-1:0] hdr;
        logic [MD_W-1:0]  rx;
    } eng_t;

    eng_t st_d, st_q;
    logic serial_bit;

    // Bits after the preamble come from the loaded word, MSB first.
    always_comb begin
        if (st_q.idx < IDX_W'(PRE_BITS)) serial_bit = 1'b1;
        else                             serial_bit = st_q.hdr[~st_q.idx[$clog2(HDR_W)-1:0]];
    end

    assign active   = st_q.active;
    assign mdio_out = !st_q.active || serial_bit;
    assign mdio_oe  = st_q.active && (st_q.wr || (st_q.idx < IDX_W'(TA_FIRST)));
    assign rx_word  = st_q.rx;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (!st_q.active) begin
            if (launch) begin
                st_d.active = 1'b1;
                st_d.wr     = launch_wr;
                st_d.idx    = '0;
                st_d.hdr    = {2'b01, (launch_wr ? OP_WRITE : OP_READ),
                               launch_phy, launch_reg, 2'b10, launch_txd};
                st_d.rx     = '0;
            end
        end else begin
            if (rise_tick && !st_q.wr && (st_q.idx >= IDX_W'(DATA_FIRST)))
                st_d.rx = {st_q.rx[MD_W-2:0], mdio_in};
            if (fall_tick) begin
                if (st_q.idx == IDX_W'(FRAME_BITS - 1)) begin
                    st_d.active = 1'b0;
                    done        = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
    import mdm_pkg::*;
#(
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in,
    output logic              irq
);
    localparam int unsigned CTRL_W = 3 + REG_AW;

    typedef struct packed {
        logic              wr_sel;
        logic [REG_AW-1:0] reg_num;
        logic [DIV_W-1:0]  div;
        logic [PHY_AW-1:0] phy;
        logic [MD_W-1:0]   txd;
        logic [MD_W-1:0]   rxd;
        logic              flag;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  busy, launch, done, rise_tick, fall_tick;
    logic  [MD_W-1:0] rx_word;
    logic  ctrl_hit;

    assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(OFS_CTRL)) && !busy;
    assign launch   = ctrl_hit && wr_data[0];

    mdm_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div       (regs_q.div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdm_frame_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_wr  (wr_data[1]),
        .launch_phy (regs_q.phy),
        .launch_reg (wr_data[3 +: REG_AW]),
        .launch_txd (regs_q.txd),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .mdio_in    (mdio_in),
        .active     (busy),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe),
        .done       (done),
        .rx_word    (rx_word)
    );

    always_comb begin
        regs_d = regs_q;
        if (ctrl_hit) begin
            regs_d.wr_sel  = wr_data[1];
            regs_d.reg_num = wr_data[3 +: REG_AW];
        end
        if (wr_en && !busy && (wr_addr == ADDR_W'(OFS_DIV))) regs_d.div = wr_data[DIV_W-1:0];
        if (wr_en && !busy && (wr_addr == ADDR_W'(OFS_PHY))) regs_d.phy = wr_data[PHY_AW-1:0];
        if (wr_en && (wr_addr == ADDR_W'(OFS_TXD)))           regs_d.txd = wr_data[MD_W-1:0];
        if (wr_en && (wr_addr == ADDR_W'(OFS_IRQ)) && wr_data[0]) regs_d.flag = 1'b0;
        if (done) begin
            regs_d.flag = 1'b1;
            if (!regs_q.wr_sel) regs_d.rxd = rx_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(OFS_CTRL): rd_data[CTRL_W-1:0] = {regs_q.reg_num, 1'b0, regs_q.wr_sel, busy};
            ADDR_W'(OFS_DIV):  rd_data[DIV_W-1:0]  = regs_q.div;
            ADDR_W'(OFS_PHY):  rd_data[PHY_AW-1:0] = regs_q.phy;
            ADDR_W'(OFS_TXD):  rd_data[MD_W-1:0]   = regs_q.txd;
            ADDR_W'(OFS_RXD):  rd_data[MD_W-1:0]   = regs_q.rxd;
            ADDR_W'(OFS_IRQ):  rd_data[0]          = regs_q.flag;
            default:           rd_data = '0;
        endcase
    end

    assign irq = regs_q.flag;
endmodule

// File: rtl/mdm_checker.sv
module mdm_checker #(
    parameter int unsigned DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mdc,
    input logic             mdio_out,
    input logic             mdio_oe,
    input logic             irq,
    input logic [4:0]       phy,
    input logic [DIV_W-1:0] div
);
    a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    a_r5_oe_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    a_r7_out_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_out));

    a_r8_end_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    a_r9_phy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(phy));

    a_r11_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(div));
endmodule

bind mgmt_serial_master mdm_checker #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .irq      (irq),
    .phy      (regs_q.phy),
    .div      (regs_q.div)
);

// File: tb/mgmt_serial_master_tb.sv
module mgmt_serial_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        mdc, mdio_out, mdio_oe, irq;
    logic        mdio_in = 1'b0;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;

    int unsigned rises = 0, falls = 0, oe_cnt = 0;
    logic [63:0] cap = '0;
    logic [15:0] phy_val = '0;

    always #10 clk = !clk;

    mgmt_serial_master u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .mdio_in(mdio_in), .irq(irq)
    );

    // PHY model: records every bit at mdc rise, drives read data after mdc fall.
    always @(posedge mdc) begin
        cap = {cap[62:0], mdio_out};
        if (mdio_oe) oe_cnt++;
        rises++;
    end
    always @(negedge mdc) begin
        falls++;
        if (falls >= 48 && falls < 64) mdio_in = phy_val[63 - falls];
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] frame_of(input bit wr, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] txd);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, txd};
    endfunction

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic run_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] txd, input logic [15:0] rxv,
                             input logic [7:0] dv, input bit poke);
        int unsigned n, seen;
        bit busy;
        logic [31:0] r;
        logic [63:0] exp;
        bus_write(3'd1, {24'd0, dv});
        bus_write(3'd2, {27'd0, phy});
        bus_write(3'd3, {16'd0, txd});
        rises = 0; falls = 0; oe_cnt = 0; cap = '0; phy_val = rxv;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = {24'd0, rg, 1'b0, wr, 1'b1};
        @(posedge clk);
        n = 0; seen = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            wr_en = 1'b0;
            if (poke && n == 10) begin wr_en = 1'b1; wr_addr = 3'd2; wr_data = {27'd0, ~phy}; end
            if (poke && n == 12) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = {24'd0, ~rg, 3'b011}; end
            if (poke && n == 14) begin wr_en = 1'b1; wr_addr = 3'd1; wr_data = {24'd0, dv + 8'd1}; end
            rd_addr = 3'd0;
            #1 busy = rd_data[0];
            if (busy) seen++;
        end while (busy && n < 40000);
        // R2 / R11: frame length in system cycles
        check(n == 128 * (int'(dv) + 1), poke ? "R11 frame length" : "R2 frame length",
              64'(n), 64'(128 * (int'(dv) + 1)));
        // R3: busy read 1 on every cycle before the end, 0 after
        check(seen == n - 1, "R3 busy during frame", 64'(seen), 64'(n - 1));
        check(rd_data[0] == 1'b0, "R3 busy cleared", 64'(rd_data[0]), 64'd0);
        exp = frame_of(wr, phy, rg, txd);
        if (wr) begin
            check(cap == exp, "R4 R7 write frame bits", cap, exp);
            check(oe_cnt == 64, "R4 write oe", 64'(oe_cnt), 64'd64);
        end else begin
            check(cap[63:18] == exp[63:18], "R5 read frame bits", 64'(cap[63:18]), 64'(exp[63:18]));
            check(oe_cnt == 46, "R5 read oe release", 64'(oe_cnt), 64'd46);
            bus_read(3'd4, r);
            check(r[15:0] == rxv, "R6 read data", 64'(r), 64'(rxv));
        end
        check(irq == 1'b1, "R8 flag on completion", 64'(irq), 64'd1);
        if (poke) begin
            bus_read(3'd2, r);
            check(r[4:0] == phy, "R9 phy write ignored", 64'(r), 64'(phy));
            repeat (20) @(posedge clk);
            bus_read(3'd0, r);
            check(r[0] == 1'b0 && rises == 64, "R10 no restart", 64'(rises), 64'd64);
            check(r[7:3] == rg, "R10 reg number kept", 64'(r[7:3]), 64'(rg));
        end
        bus_write(3'd5, 32'd0);
        @(negedge clk);
        check(irq == 1'b1, "R8 zero write keeps flag", 64'(irq), 64'd1);
        bus_write(3'd5, 32'd1);
        @(negedge clk);
        check(irq == 1'b0, "R8 flag cleared", 64'(irq), 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=hang expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        check(mdc == 1'b0 && mdio_oe == 1'b0 && irq == 1'b0 && mdio_out == 1'b1,
              "R1 pins after reset", {mdc, mdio_oe, irq, mdio_out}, 64'b0001);
        for (int a = 0; a < 6; a++) begin
            bus_read(3'(a), r);
            check(r == 32'd0, "R1 register reset", 64'(r), 64'd0);
        end
        // directed corners
        run_frame(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000, 8'd0, 1'b0);
        run_frame(1'b0, 5'h00, 5'h00, 16'h0000, 16'hFFFF, 8'd0, 1'b0);
        run_frame(1'b0, 5'h15, 5'h0A, 16'h1234, 16'h8001, 8'd255, 1'b0);
        run_frame(1'b1, 5'h0C, 5'h13, 16'hA5C3, 16'h0000, 8'd2, 1'b1);
        run_frame(1'b0, 5'h03, 5'h11, 16'h0000, 16'h5AA5, 8'd1, 1'b1);
        // random frames
        for (int i = 0; i < 10; i++) begin
            run_frame(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                      16'($urandom), 8'($urandom % 4), 1'b0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule